// File: doc/BRIEF.md
# TDD Synthesizer Calibration Sequencer

This block sequences VCO calibration for a transceiver that has one receive synthesizer and one transmit synthesizer. It follows the device operating state from a few hardware control lines: an enable line whose rising edges advance the state, a direction line that selects transmit (high) or receive (low), and plain wake, sleep and power-down commands. From this state it decides which synthesizer is powered. It also decides when each synthesizer needs a fresh VCO calibration.

Calibration requests come from three places: entry into the alert state from wait or from synthesizer power-down, a change of the direction line while in alert in time-division mode, and a write strobe for either synthesizer's frequency integer word. All requests are collected as pending bits, one per synthesizer. A single calibration engine is then driven through a start-pulse/done handshake. No request is issued before charge-pump calibration reports done, and none is lost when it arrives during a running calibration. The engine also receives a cycle budget, chosen by a fast/slow select: the short one suits time-division operation and the long one suits frequency-division operation. All pins are plain control and status levels or one-cycle pulses. There is no streaming data path, so there is no back-pressure.

Top module: `synth_cal_seq`

## Requirements
- R1: After reset, state_o is 0 (wait), both power outputs are low, cal_busy_o is low and cal_start_o is low.
- R2: State codes are wait=0, alert=1, receive=2, transmit=3, power-down=4. wake_i moves wait to alert. In alert, a rising edge of en_i moves to receive when txnrx_i is low and to transmit when it is high. In receive or transmit, a rising edge of en_i returns to alert. sleep_i in alert moves to wait. The state never leaves alert without one of these inputs.
- R3: Entering alert from wait or power-down requests calibration. In time-division mode (tdd_mode_i high) this covers only the synthesizer chosen by txnrx_i (0 = receive, 1 = transmit). In frequency-division mode it covers both.
- R4: A pulse on fw_rx_i or fw_tx_i requests calibration of that synthesizer in any state.
- R5: In alert in time-division mode, when txnrx_i differs from the powered selection, power swaps to the other synthesizer one cycle later and a calibration of the newly powered synthesizer is requested. The state itself does not change.
- R6: Power map: in wait and power-down neither synthesizer is powered. In time-division mode, receive powers only Rx, transmit powers only Tx, and alert powers the selected one. In frequency-division mode both are powered in alert, receive and transmit. txnrx_i changes in receive or transmit do not change power.
- R7: pd_i in alert moves to power-down only in time-division mode. In frequency-division mode it is ignored.
- R8: No cal_start_o pulse occurs while cp_done_i is low. A request held during that time is issued on the first clock edge at which cp_done_i is high.
- R9: cal_start_o is a one-cycle pulse, with cal_tx_o naming the synthesizer (0 = Rx, 1 = Tx). With the engine idle, it appears after the second clock edge following the request. cal_busy_o is high from the start pulse until the edge at which cal_done_i is sampled high.
- R10: cal_budget_o is FAST_CYC when cal_slow_i is low at the start pulse and SLOW_CYC when it is high. It is held for the whole calibration.
- R11: A request for a synthesizer that arrives while a calibration is running is issued after that calibration finishes and is never dropped. When both synthesizers are pending, Rx is issued first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable line; rising edges advance the state |
| txnrx_i | input | 1 | Direction line, 1 = transmit |
| tdd_mode_i | input | 1 | 1 = time-division, 0 = frequency-division |
| wake_i | input | 1 | Leave wait or power-down for alert |
| sleep_i | input | 1 | Leave alert for wait |
| pd_i | input | 1 | Leave alert for synthesizer power-down (time-division only) |
| fw_rx_i | input | 1 | Rx frequency integer word low-byte write strobe |
| fw_tx_i | input | 1 | Tx frequency integer word low-byte write strobe |
| cp_done_i | input | 1 | Charge-pump calibration complete |
| cal_slow_i | input | 1 | 1 selects the long calibration budget |
| cal_done_i | input | 1 | Calibration engine finished |
| cal_start_o | output | 1 | One-cycle calibration start pulse |
| cal_tx_o | output | 1 | Synthesizer being calibrated, 1 = Tx |
| cal_budget_o | output | BW | Cycle budget for the calibration engine |
| cal_busy_o | output | 1 | Calibration in progress |
| pwr_rx_o | output | 1 | Rx synthesizer power enable |
| pwr_tx_o | output | 1 | Tx synthesizer power enable |
| state_o | output | 3 | Operating state code |

## Verification
The hardest situations to reach are a repeated request for the synthesizer already being calibrated, and both synthesizers pending at once. Both need a request to arrive inside the busy window. The bench plays the calibration engine itself and holds cal_done_i low, which keeps that window open while it fires strobes for one or both synthesizers. It then releases done and checks the order and number of the start pulses that follow. Gating on charge-pump calibration is reached the same way: cp_done_i is held low across a request, and the bench checks that the start pulse comes out on the first edge after it rises.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_ALERT = 3'd1,
    ST_RX    = 3'd2,
    ST_TX    = 3'd3,
    ST_PD    = 3'd4
  } op_state_t;

  localparam int NSYN   = 2;
  localparam int SYN_RX = 0;
  localparam int SYN_TX = 1;
  localparam int SYN_IW = (NSYN > 1) ? $clog2(NSYN) : 1;
endpackage

// File: rtl/scs_mode_fsm.sv
module scs_mode_fsm
  import scs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            txnrx_i,
  input  logic            tdd_i,
  input  logic            wake_i,
  input  logic            sleep_i,
  input  logic            pd_i,
  output op_state_t       state_o,
  output logic [NSYN-1:0] trig_o,
  output logic [NSYN-1:0] pwr_o
);
  op_state_t st_q, st_n;
  logic      sel_q, sel_n;
  logic      en_q;
  logic      en_rise;

  assign en_rise = en_i & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      sel_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      st_q  <= st_n;
      sel_q <= sel_n;
      en_q  <= en_i;
    end
  end

  // next state, selection and calibration requests
  always_comb begin
    st_n   = st_q;
    sel_n  = sel_q;
    trig_o = '0;
    case (st_q)
      ST_WAIT: begin
        if (wake_i) begin
          st_n  = ST_ALERT;
          sel_n = txnrx_i;
          if (tdd_i) trig_o[txnrx_i] = 1'b1;
          else       trig_o = '1;
        end
      end
      ST_PD: begin
        if (wake_i) begin
          st_n  = ST_ALERT;
          sel_n = txnrx_i;
          trig_o[txnrx_i] = 1'b1;
        end
      end
      ST_ALERT: begin
        if (tdd_i && (txnrx_i != sel_q)) begin
          sel_n = txnrx_i;
          trig_o[txnrx_i] = 1'b1;
        end
        if (en_rise) begin
          st_n  = txnrx_i ? ST_TX : ST_RX;
          sel_n = txnrx_i;
        end else if (sleep_i) begin
          st_n = ST_WAIT;
        end else if (pd_i && tdd_i) begin
          st_n = ST_PD;
        end
      end
      ST_RX, ST_TX: begin
        if (en_rise) st_n = ST_ALERT;
      end
      default: st_n = ST_WAIT;
    endcase
  end

  // power map
  always_comb begin
    case (st_q)
      ST_WAIT, ST_PD: pwr_o = '0;
      default: begin
        if (!tdd_i)             pwr_o = '1;
        else if (st_q == ST_RX) pwr_o = NSYN'(1) << SYN_RX;
        else if (st_q == ST_TX) pwr_o = NSYN'(1) << SYN_TX;
        else if (sel_q)         pwr_o = NSYN'(1) << SYN_TX;
        else                    pwr_o = NSYN'(1) << SYN_RX;
      end
    endcase
  end

  assign state_o = st_q;
endmodule

// File: rtl/scs_trig_collect.sv
module scs_trig_collect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_pend
    // a set arriving with the grant keeps the bit, so nothing is lost
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= (pend_q[g] & ~clr_i[g]) | set_i[g];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/scs_cal_issue.sv
module scs_cal_issue #(
  parameter int N        = 2,
  parameter int FAST_CYC = 48,
  parameter int SLOW_CYC = 640,
  parameter int BW       = 10,
  parameter int IW       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic          cp_done_i,
  input  logic          slow_i,
  input  logic          done_i,
  output logic [N-1:0]  clr_o,
  output logic          start_o,
  output logic [IW-1:0] sel_o,
  output logic [BW-1:0] budget_o,
  output logic          busy_o
);
  localparam logic [BW-1:0] FAST_V = BW'(FAST_CYC);
  localparam logic [BW-1:0] SLOW_V = BW'(SLOW_CYC);

  logic          busy_q, start_q;
  logic [IW-1:0] sel_q, pick;
  logic [BW-1:0] bud_q;
  logic          grant;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) pick = IW'(i);
    end
  end

  assign grant = !busy_q && cp_done_i && (|pend_i);
  assign clr_o = grant ? (N'(1) << pick) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      sel_q   <= '0;
      bud_q   <= '0;
    end else begin
      start_q <= grant;
      if (grant) begin
        busy_q <= 1'b1;
        sel_q  <= pick;
        bud_q  <= slow_i ? SLOW_V : FAST_V;
      end else if (busy_q && done_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign start_o  = start_q;
  assign sel_o    = sel_q;
  assign budget_o = bud_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/synth_cal_seq.sv
module synth_cal_seq
  import scs_pkg::*;
#(
  parameter int FAST_CYC = 48,
  parameter int SLOW_CYC = 640,
  localparam int BW      = $clog2(SLOW_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          txnrx_i,
  input  logic          tdd_mode_i,
  input  logic          wake_i,
  input  logic          sleep_i,
  input  logic          pd_i,
  input  logic          fw_rx_i,
  input  logic          fw_tx_i,
  input  logic          cp_done_i,
  input  logic          cal_slow_i,
  input  logic          cal_done_i,
  output logic          cal_start_o,
  output logic          cal_tx_o,
  output logic [BW-1:0] cal_budget_o,
  output logic          cal_busy_o,
  output logic          pwr_rx_o,
  output logic          pwr_tx_o,
  output logic [2:0]    state_o
);
  op_state_t         st;
  logic [NSYN-1:0]   fsm_trig, pwr, req, pend, clr;
  logic [SYN_IW-1:0] sel;

  scs_mode_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .txnrx_i (txnrx_i),
    .tdd_i   (tdd_mode_i),
    .wake_i  (wake_i),
    .sleep_i (sleep_i),
    .pd_i    (pd_i),
    .state_o (st),
    .trig_o  (fsm_trig),
    .pwr_o   (pwr)
  );

  always_comb begin
    req = fsm_trig;
    req[SYN_RX] = req[SYN_RX] | fw_rx_i;
    req[SYN_TX] = req[SYN_TX] | fw_tx_i;
  end

  scs_trig_collect #(.N(NSYN)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (req),
    .clr_i  (clr),
    .pend_o (pend)
  );

  scs_cal_issue #(
    .N        (NSYN),
    .FAST_CYC (FAST_CYC),
    .SLOW_CYC (SLOW_CYC),
    .BW       (BW),
    .IW       (SYN_IW)
  ) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend),
    .cp_done_i (cp_done_i),
    .slow_i    (cal_slow_i),
    .done_i    (cal_done_i),
    .clr_o     (clr),
    .start_o   (cal_start_o),
    .sel_o     (sel),
    .budget_o  (cal_budget_o),
    .busy_o    (cal_busy_o)
  );

  assign cal_tx_o = sel[0];
  assign pwr_rx_o = pwr[SYN_RX];
  assign pwr_tx_o = pwr[SYN_TX];
  assign state_o  = st;
endmodule

// File: rtl/synth_cal_seq_chk.sv
module synth_cal_seq_chk #(
  parameter int BW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic          txnrx_i,
  input logic          tdd_mode_i,
  input logic          cp_done_i,
  input logic          cal_done_i,
  input logic          cal_start_o,
  input logic [BW-1:0] cal_budget_o,
  input logic          cal_busy_o,
  input logic          pwr_rx_o,
  input logic          pwr_tx_o,
  input logic [2:0]    state_o
);
  // R8
  start_needs_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |-> $past(cp_done_i));

  // R9
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |-> (cal_busy_o && !$past(cal_busy_o)));

  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start_o |=> !cal_start_o);

  // R9
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy_o && cal_done_i) |=> !cal_busy_o);

  // R10
  budget_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy_o && !cal_start_o) |-> $stable(cal_budget_o));

  // R6
  idle_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd0) || (state_o == 3'd4)) |-> (!pwr_rx_o && !pwr_tx_o));

  // R2
  alert_to_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd2) && ($past(state_o) == 3'd1)) |-> ($past(en_i) && !$past(txnrx_i)));

  // R2
  alert_to_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd3) && ($past(state_o) == 3'd1)) |-> ($past(en_i) && $past(txnrx_i)));

  // R7
  pd_only_tdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd4) && ($past(state_o) == 3'd1)) |-> $past(tdd_mode_i));
endmodule

bind synth_cal_seq synth_cal_seq_chk #(.BW(BW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .txnrx_i      (txnrx_i),
  .tdd_mode_i   (tdd_mode_i),
  .cp_done_i    (cp_done_i),
  .cal_done_i   (cal_done_i),
  .cal_start_o  (cal_start_o),
  .cal_budget_o (cal_budget_o),
  .cal_busy_o   (cal_busy_o),
  .pwr_rx_o     (pwr_rx_o),
  .pwr_tx_o     (pwr_tx_o),
  .state_o      (state_o)
);

// File: tb/synth_cal_seq_tb_top.sv
module synth_cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FAST_C = 48;
  localparam int SLOW_C = 640;
  localparam int BW = $clog2(SLOW_C + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 0, txnrx_i = 0, tdd_mode_i = 1, wake_i = 0, sleep_i = 0, pd_i = 0;
  logic fw_rx_i = 0, fw_tx_i = 0, cp_done_i = 1, cal_slow_i = 0, cal_done_i = 0;
  logic cal_start_o, cal_tx_o, cal_busy_o, pwr_rx_o, pwr_tx_o;
  logic [BW-1:0] cal_budget_o;
  logic [2:0] state_o;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  synth_cal_seq #(.FAST_CYC(FAST_C), .SLOW_CYC(SLOW_C)) dut_i (
    .clk (clk), .rst_n (rst_n), .en_i (en_i), .txnrx_i (txnrx_i),
    .tdd_mode_i (tdd_mode_i), .wake_i (wake_i), .sleep_i (sleep_i), .pd_i (pd_i),
    .fw_rx_i (fw_rx_i), .fw_tx_i (fw_tx_i), .cp_done_i (cp_done_i),
    .cal_slow_i (cal_slow_i), .cal_done_i (cal_done_i),
    .cal_start_o (cal_start_o), .cal_tx_o (cal_tx_o), .cal_budget_o (cal_budget_o),
    .cal_busy_o (cal_busy_o), .pwr_rx_o (pwr_rx_o), .pwr_tx_o (pwr_tx_o),
    .state_o (state_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fw_pulse(input bit tx);
    if (tx) fw_tx_i = 1'b1; else fw_rx_i = 1'b1;
    step(1);
    fw_tx_i = 1'b0;
    fw_rx_i = 1'b0;
  endtask

  task automatic wake_pulse();
    wake_i = 1'b1;
    step(1);
    wake_i = 1'b0;
  endtask

  // waits for a start pulse and checks edges waited, synthesizer and budget
  task automatic expect_start(input string req, input int lat, input bit tx, input int bud);
    int n = 0;
    while (!cal_start_o && n < 8) begin
      step(1);
      n++;
    end
    chk({req, " start latency"}, n, lat);
    chk({req, " synth"}, int'(cal_tx_o), int'(tx));
    chk({req, " budget"}, int'(cal_budget_o), bud);
    chk({req, " busy"}, int'(cal_busy_o), 1);
  endtask

  task automatic finish_cal();
    cal_done_i = 1'b1;
    step(1);
    cal_done_i = 1'b0;
    chk("R9 busy after done", int'(cal_busy_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 state", int'(state_o), 0);
    chk("R1 pwr", int'({pwr_tx_o, pwr_rx_o}), 0);
    chk("R1 busy", int'(cal_busy_o), 0);
    chk("R1 start", int'(cal_start_o), 0);

    // R3 wake from wait, TDD, receive selected
    wake_pulse();
    chk("R2 wait->alert", int'(state_o), 1);
    chk("R6 alert rx power", int'({pwr_tx_o, pwr_rx_o}), 1);
    expect_start("R3 wake tdd", 1, 1'b0, FAST_C);
    finish_cal();

    // R4 / R10 sweep over budget select and synthesizer
    for (int sl = 0; sl < 2; sl++) begin
      for (int s = 0; s < 2; s++) begin
        cal_slow_i = sl[0];
        fw_pulse(s[0]);
        expect_start("R4 write strobe", 1, s[0], sl ? SLOW_C : FAST_C);
        step(1);
        chk("R9 single pulse", int'(cal_start_o), 0);
        cal_slow_i = ~sl[0];
        step(2);
        chk("R10 budget held", int'(cal_budget_o), sl ? SLOW_C : FAST_C);
        chk("R9 busy held", int'(cal_busy_o), 1);
        cal_slow_i = 1'b0;
        finish_cal();
      end
    end

    // R8 charge-pump gating
    cp_done_i = 1'b0;
    fw_pulse(1'b1);
    step(4);
    chk("R8 no start", int'(cal_start_o), 0);
    chk("R8 not busy", int'(cal_busy_o), 0);
    cp_done_i = 1'b1;
    expect_start("R8 released", 1, 1'b1, FAST_C);
    finish_cal();

    // R5 direction change in alert
    txnrx_i = 1'b1;
    step(1);
    chk("R5 swap power", int'({pwr_tx_o, pwr_rx_o}), 2);
    expect_start("R5 tx cal", 1, 1'b1, FAST_C);
    chk("R5 state kept", int'(state_o), 1);
    finish_cal();

    // R2 / R6 enable edges
    en_i = 1'b1;
    step(1);
    chk("R2 alert->tx", int'(state_o), 3);
    chk("R6 tx power", int'({pwr_tx_o, pwr_rx_o}), 2);
    txnrx_i = 1'b0;
    step(2);
    chk("R6 txnrx ignored", int'({pwr_tx_o, pwr_rx_o}), 2);
    chk("R6 no cal in tx", int'(cal_start_o), 0);
    en_i = 1'b0;
    step(1);
    en_i = 1'b1;
    step(1);
    en_i = 1'b0;
    chk("R2 tx->alert", int'(state_o), 1);
    step(1);
    chk("R5 swap back", int'({pwr_tx_o, pwr_rx_o}), 1);
    expect_start("R5 rx cal", 1, 1'b0, FAST_C);
    finish_cal();
    en_i = 1'b1;
    step(1);
    chk("R2 alert->rx", int'(state_o), 2);
    chk("R6 rx power", int'({pwr_tx_o, pwr_rx_o}), 1);
    en_i = 1'b0;
    step(1);
    en_i = 1'b1;
    step(1);
    en_i = 1'b0;
    chk("R2 rx->alert", int'(state_o), 1);

    // R11 requests during a running calibration
    fw_pulse(1'b0);
    expect_start("R11 first", 1, 1'b0, FAST_C);
    fw_pulse(1'b0);
    fw_pulse(1'b1);
    step(2);
    chk("R11 held while busy", int'(cal_start_o), 0);
    finish_cal();
    chk("R9 gap after done", int'(cal_start_o), 0);
    expect_start("R11 rx again", 1, 1'b0, FAST_C);
    finish_cal();
    expect_start("R11 tx next", 1, 1'b1, FAST_C);
    finish_cal();
    step(3);
    chk("R11 no extra", int'(cal_start_o), 0);
    chk("R11 idle", int'(cal_busy_o), 0);

    // R7 / R3 power-down in TDD
    pd_i = 1'b1;
    step(1);
    pd_i = 1'b0;
    chk("R7 enter pd", int'(state_o), 4);
    chk("R6 pd power", int'({pwr_tx_o, pwr_rx_o}), 0);
    txnrx_i = 1'b1;
    step(1);
    wake_pulse();
    chk("R2 pd->alert", int'(state_o), 1);
    chk("R6 alert tx power", int'({pwr_tx_o, pwr_rx_o}), 2);
    expect_start("R3 wake from pd", 1, 1'b1, FAST_C);
    finish_cal();

    // R7 / R3 frequency-division
    tdd_mode_i = 1'b0;
    pd_i = 1'b1;
    step(1);
    pd_i = 1'b0;
    chk("R7 pd ignored", int'(state_o), 1);
    chk("R6 fdd power", int'({pwr_tx_o, pwr_rx_o}), 3);
    txnrx_i = 1'b0;
    step(3);
    chk("R5 no swap fdd", int'(cal_start_o), 0);
    sleep_i = 1'b1;
    step(1);
    sleep_i = 1'b0;
    chk("R2 sleep", int'(state_o), 0);
    wake_pulse();
    expect_start("R3 fdd rx", 1, 1'b0, FAST_C);
    finish_cal();
    expect_start("R3 fdd tx", 1, 1'b1, FAST_C);
    finish_cal();
    txnrx_i = 1'b1;
    en_i = 1'b1;
    step(1);
    en_i = 1'b0;
    chk("R2 fdd tx", int'(state_o), 3);
    chk("R6 fdd tx power", int'({pwr_tx_o, pwr_rx_o}), 3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule